// File: doc/BRIEF.md
# Four-Way Recency Order Tracker

This block holds the replacement state of a single set in a four-way set-associative cache. It keeps the complete least-to-most-recent order of the four ways, not an approximation of it. The order is stored as a 5-bit packed code. The code gives the index of the newest way, then the index of the next-newest way, then one bit that says which of the two remaining ways was used more recently.

On every access the cache controller presents a strobe, a hit/miss flag and, for a hit, the way that matched. On a hit, that way becomes the newest. On a miss, the oldest way is reported as the victim to refill, and it becomes the newest. The packed code is a port of the block, so a larger design can keep one code per set in its own storage. Tag comparison and line data are handled outside this block.

Top module: `lru4_tracker`

## Requirements
- R1: While `rst` is high at a rising clock edge, the order becomes (0,1,2,3) from newest to oldest. That order packs to `lru_state` = 5'b00_01_0.
- R2: `lru_state` packs the current order as follows. Bits [4:3] hold the newest way and bits [2:1] hold the second-newest way. Bit 0 is 1 when the larger of the two remaining way indices is the more recent of them, and 0 when the smaller one is. Examples: order (2,0,1,3) gives 10_00_0, order (3,2,1,0) gives 11_10_1, and order (3,2,0,1) gives 11_10_0.
- R3: An accepted hit on way w (`acc_valid`=1, `acc_hit`=1, `hit_way`=w) makes w the newest way from the next cycle on. The other three ways keep their relative order. Example: (0,1,2,3) with a hit on 2 gives (2,0,1,3).
- R4: An accepted hit on the way that is already newest leaves the order and `lru_state` unchanged.
- R5: An accepted miss (`acc_valid`=1, `acc_hit`=0) moves the oldest way to the front and keeps the order of the others. Example: (1,2,0,3) gives (3,1,2,0).
- R6: `victim_way` always shows the oldest way of the current order, so during a miss it names the way being replaced.
- R7: The state changes only on cycles with `acc_valid`=1. `hit_way` has no effect when `acc_hit`=0.
- R8: `rank_ways` shows the whole current order. Bits [2k+1:2k] hold the way at rank k, where rank 0 is the newest. The four fields are always a permutation of 0..3.
- R9: The two leading fields of `lru_state` never hold the same way index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access to this set happens this cycle |
| acc_hit | input | 1 | 1 = the access hit, 0 = the access missed |
| hit_way | input | 2 | Way that matched on a hit |
| victim_way | output | 2 | Oldest way, which is replaced on a miss |
| lru_state | output | 5 | Packed recency code |
| rank_ways | output | 8 | Full order, newest way in bits [1:0] |

## Verification
The main loop starts from each of the 24 possible orders, which it reaches with a series of hits. From each order it applies a hit on each of the four ways and a miss. This separates a hit at the front, in the middle and at the back of the list from a miss, and it covers both values of the hidden-pair bit for every pair. A short table of known transitions and packed codes pins down the exact bit layout. Directed steps then show three further cases: idle cycles do not change the state, `hit_way` is ignored on a miss, and a reset in the middle of a run brings the state back to its start value.

// File: rtl/lru4_pkg.sv
package lru4_pkg;

    localparam int NUM_WAYS = 4;
    localparam int WAY_W    = $clog2(NUM_WAYS);
    localparam int HIDDEN   = 2;
    localparam int STATE_W  = (NUM_WAYS - HIDDEN) * WAY_W + 1;
    localparam int ORDER_W  = NUM_WAYS * WAY_W;

    typedef logic [WAY_W-1:0] way_t;

    // rank 0 = newest, rank NUM_WAYS-1 = oldest
    typedef way_t [NUM_WAYS-1:0] order_t;

    typedef struct packed {
        way_t newest;
        way_t second;
        logic upper_newer;   // larger hidden index is the more recent one
    } lru_code_t;

    localparam lru_code_t RESET_CODE = '{newest: way_t'(0), second: way_t'(1), upper_newer: 1'b0};

endpackage

// File: rtl/lru4_unpack.sv
module lru4_unpack
    import lru4_pkg::*;
(
    input  lru_code_t code,
    output order_t    order
);
    way_t lo_way;
    way_t hi_way;
    logic lo_found;

    always_comb begin
        lo_way   = '0;
        hi_way   = '0;
        lo_found = 1'b0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (way_t'(i) != code.newest && way_t'(i) != code.second) begin
                if (!lo_found) begin
                    lo_way   = way_t'(i);
                    lo_found = 1'b1;
                end else begin
                    hi_way = way_t'(i);
                end
            end
        end
    end

    always_comb begin
        order[0] = code.newest;
        order[1] = code.second;
        order[2] = code.upper_newer ? hi_way : lo_way;
        order[3] = code.upper_newer ? lo_way : hi_way;
    end

endmodule

// File: rtl/lru4_promote.sv
module lru4_promote
    import lru4_pkg::*;
(
    input  order_t cur,
    input  logic   hit,
    input  way_t   way,
    output order_t nxt,
    output way_t   victim
);
    way_t target;
    way_t target_pos;

    assign victim = cur[NUM_WAYS-1];
    assign target = hit ? way : victim;

    always_comb begin
        target_pos = way_t'(NUM_WAYS - 1);
        for (int p = NUM_WAYS - 1; p >= 0; p--) begin
            if (cur[p] == target) target_pos = way_t'(p);
        end
    end

    assign nxt[0] = target;

    for (genvar k = 1; k < NUM_WAYS; k++) begin : g_shift
        // ranks at or above the target slide down by one
        assign nxt[k] = (target_pos >= way_t'(k)) ? cur[k-1] : cur[k];
    end

endmodule

// File: rtl/lru4_pack.sv
module lru4_pack
    import lru4_pkg::*;
(
    input  order_t    order,
    output lru_code_t code
);
    always_comb begin
        code.newest      = order[0];
        code.second      = order[1];
        code.upper_newer = (order[2] > order[3]);
    end

endmodule

// File: rtl/lru4_tracker.sv
module lru4_tracker
    import lru4_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_valid,
    input  logic               acc_hit,
    input  logic [WAY_W-1:0]   hit_way,
    output logic [WAY_W-1:0]   victim_way,
    output logic [STATE_W-1:0] lru_state,
    output logic [ORDER_W-1:0] rank_ways
);
    lru_code_t code_q;
    lru_code_t code_d;
    order_t    cur_order;
    order_t    nxt_order;
    way_t      victim;

    lru4_unpack u_unpack (
        .code  (code_q),
        .order (cur_order)
    );

    lru4_promote u_promote (
        .cur    (cur_order),
        .hit    (acc_hit),
        .way    (hit_way),
        .nxt    (nxt_order),
        .victim (victim)
    );

    lru4_pack u_pack (
        .order (nxt_order),
        .code  (code_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= RESET_CODE;
        end else if (acc_valid) begin
            code_q <= code_d;
        end
    end

    assign victim_way = victim;
    assign lru_state  = code_q;
    assign rank_ways  = cur_order;

endmodule

// File: rtl/lru4_tracker_chk.sv
module lru4_tracker_chk (
    input logic       clk,
    input logic       rst,
    input logic       acc_valid,
    input logic       acc_hit,
    input logic [1:0] hit_way,
    input logic [1:0] victim_way,
    input logic [4:0] lru_state,
    input logic [7:0] rank_ways
);
    assert_reset_code_R1: assert property (@(posedge clk)
        rst |=> lru_state == 5'b00_01_0);

    assert_fields_differ_R9: assert property (@(posedge clk) disable iff (rst)
        lru_state[4:3] != lru_state[2:1]);

    assert_hit_to_front_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_hit) |=> lru_state[4:3] == $past(hit_way));

    assert_front_hit_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_hit && hit_way == lru_state[4:3]) |=> $stable(lru_state));

    assert_miss_victim_front_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_hit) |=> lru_state[4:3] == $past(victim_way));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> $stable(lru_state));

    assert_victim_not_newest_R6: assert property (@(posedge clk) disable iff (rst)
        victim_way != lru_state[4:3]);

    assert_rank_newest_R8: assert property (@(posedge clk) disable iff (rst)
        rank_ways[1:0] == lru_state[4:3]);

endmodule

bind lru4_tracker lru4_tracker_chk i_chk (.*);

// File: tb/test_lru4_tracker.sv
module test_lru4_tracker;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 1'b0;
    logic       acc_hit = 1'b0;
    logic [1:0] hit_way = 2'd0;
    logic [1:0] victim_way;
    logic [4:0] lru_state;
    logic [7:0] rank_ways;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lru4_tracker i_lru4_tracker (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (acc_valid),
        .acc_hit    (acc_hit),
        .hit_way    (hit_way),
        .victim_way (victim_way),
        .lru_state  (lru_state),
        .rank_ways  (rank_ways)
    );

    // {start order, hit flag, way, expected order}; order fields: rank k in [2k+1:2k]
    localparam int NDIR = 6;
    localparam logic [18:0] DIRECTED [NDIR] = '{
        {8'hE4, 1'b1, 2'd2, 8'hD2},
        {8'hD2, 1'b1, 2'd1, 8'hC9},
        {8'hC9, 1'b0, 2'd0, 8'h27},
        {8'h27, 1'b1, 2'd3, 8'h27},
        {8'h1B, 1'b0, 2'd2, 8'h6C},
        {8'h4B, 1'b1, 2'd0, 8'h6C}
    };

    function automatic logic [4:0] ref_code(input logic [7:0] o);
        return {o[1:0], o[3:2], (o[5:4] > o[7:6])};
    endfunction

    function automatic logic [7:0] ref_next(input logic [7:0] o, input logic hit, input logic [1:0] w);
        logic [1:0] tgt;
        logic [7:0] r;
        int n;
        tgt = hit ? w : o[7:6];
        r = '0;
        r[1:0] = tgt;
        n = 1;
        for (int k = 0; k < 4; k++) begin
            if (o[2*k +: 2] != tgt) begin
                r[2*n +: 2] = o[2*k +: 2];
                n++;
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic v, input logic h, input logic [1:0] w);
        acc_valid = v;
        acc_hit   = h;
        hit_way   = w;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_hit   = 1'b0;
    endtask

    task automatic set_order(input logic [7:0] o);
        for (int k = 3; k >= 0; k--) access(1'b1, 1'b1, o[2*k +: 2]);
    endtask

    task automatic check_state(input string req, input logic [7:0] exp_order);
        check({req, " order"}, rank_ways, exp_order);
        check({req, " code"}, {3'b0, lru_state}, {3'b0, ref_code(exp_order)});
        check({req, " victim"}, {6'b0, victim_way}, {6'b0, exp_order[7:6]});
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] start, exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 reset code", {3'b0, lru_state}, 8'h02);
        check("R1 reset order", rank_ways, 8'hE4);

        // R2 packed layout examples
        set_order(8'hD2);
        check("R2 code 2013", {3'b0, lru_state}, {3'b0, 5'b10_00_0});
        set_order(8'h1B);
        check("R2 code 3210", {3'b0, lru_state}, {3'b0, 5'b11_10_1});
        set_order(8'h4B);
        check("R2 code 3201", {3'b0, lru_state}, {3'b0, 5'b11_10_0});

        // directed table: R3 hit, R4 front hit, R5 miss
        for (int i = 0; i < NDIR; i++) begin
            set_order(DIRECTED[i][18:11]);
            check_state("R6 table pre", DIRECTED[i][18:11]);
            access(1'b1, DIRECTED[i][10], DIRECTED[i][9:8]);
            check_state(DIRECTED[i][10] ? "R3 table hit" : "R5 table miss", DIRECTED[i][7:0]);
        end

        // exhaustive: all 24 orders, each hit way and a miss
        for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
        for (int d = 0; d < 4; d++) begin
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
                start = {d[1:0], c[1:0], b[1:0], a[1:0]};
                for (int act = 0; act < 5; act++) begin
                    set_order(start);
                    check_state("R8 walk pre", start);
                    if (act < 4) begin
                        exp = ref_next(start, 1'b1, act[1:0]);
                        access(1'b1, 1'b1, act[1:0]);
                        check_state((act[1:0] == start[1:0]) ? "R4 walk front hit" : "R3 walk hit", exp);
                    end else begin
                        exp = ref_next(start, 1'b0, 2'd0);
                        access(1'b1, 1'b0, start[1:0]);
                        check_state("R5 walk miss", exp);
                    end
                end
            end
        end

        // R7 idle cycles hold state even with hit inputs toggling
        set_order(8'h6C);
        access(1'b0, 1'b1, 2'd3);
        access(1'b0, 1'b0, 2'd2);
        check_state("R7 idle hold", 8'h6C);

        // R7 hit_way ignored on miss: every hit_way value gives the same result
        for (int w = 0; w < 4; w++) begin
            set_order(8'hC9);
            access(1'b1, 1'b0, w[1:0]);
            check_state("R7 miss ignores way", 8'h27);
        end

        // R1 reset in mid-run
        set_order(8'h1B);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_state("R1 mid reset", 8'hE4);

        summary();
        $finish;
    end

endmodule